// File: doc/BRIEF.md
# Narrow Write Byte-Lane Checker

This block sits at the write side of a 32-bit slave and checks single-beat writes. It accepts an address beat and holds its address and size. It then accepts one data beat, decides which byte lanes of the bus that address and size allow, and hands the slave a result for one cycle. The result holds the address, the data, the allowed-lane window, the byte mask to write and two error flags.

The size field is a power-of-two exponent, so a beat always covers an aligned byte, halfword or word. The lane window comes only from the low address bits and the size. The write strobes can then clear lanes inside that window, so a full-word aligned beat can write any byte pattern, including patterns with gaps. Strobe bits outside the window are dropped from the mask and reported. Size codes too wide for the bus are reported, and the beat then writes nothing.

Control is a two-state machine. `WAIT_ADDR` is the state after reset: the address channel is ready and the data channel is not. An address handshake takes the transition `ADDR_TAKEN` to `WAIT_DATA`. In `WAIT_DATA` only the data channel is ready. A data handshake takes the transition `DATA_TAKEN` back to `WAIT_ADDR`, and the result registers load on that same edge.

Top module: `axi_narrow_lane_check`

## Requirements
- R1: For size code s in {0,1,2} (1, 2, 4 bytes), `lane_en` is a contiguous run of 2^s lanes. The run starts at the lane given by address bits [1:0] with their low s bits cleared. Lane i is bit i of the mask, and lane 0 is data bits [7:0].
- R2: A size code above 2 sets `size_err`, and both `lane_en` and `byte_mask` are zero for that beat. `strb_err` is 0 in that case.
- R3: `byte_mask` is `w_strb` ANDed with the lane window. Strobes can clear lanes inside the window: an aligned word beat with strobe 4'b0100 writes only lane 2.
- R4: If any strobe bit lies outside the lane window, `strb_err` is set and that lane is left out of `byte_mask`.
- R5: Strobe patterns with gaps (0101, 1001, 1010, 1011, 1101) on an aligned word beat pass to `byte_mask` unchanged, with no error.
- R6: During reset and after it, `aw_ready`=1, `w_ready`=0 and `wr_valid`=0. While `wr_valid` is 0, `lane_en`, `byte_mask`, `size_err` and `strb_err` are all 0.
- R7: `w_ready` is 0 until an address beat has been accepted. `aw_ready` and `w_ready` are never high together. A data beat offered before any address beat is not accepted.
- R8: The address and size are captured on the address handshake. Later changes on `aw_addr` or `aw_size` do not affect the result, and `wr_addr` carries the captured address.
- R9: `wr_valid` is high for exactly one cycle, in the cycle after the data handshake. `wr_data` carries that beat's data.
- R10: For a word-size beat the window is all four lanes, whatever the value of address bits [1:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| aw_addr | input | ADDR_W | Write address |
| aw_size | input | 3 | Size exponent (bytes = 2^code) |
| aw_valid | input | 1 | Address beat valid |
| aw_ready | output | 1 | Address beat accepted when high with valid |
| w_data | input | DATA_W | Write data |
| w_strb | input | DATA_W/8 | Per-lane write strobes |
| w_valid | input | 1 | Data beat valid |
| w_ready | output | 1 | Data beat accepted when high with valid |
| wr_valid | output | 1 | One-cycle result strobe |
| wr_addr | output | ADDR_W | Captured address |
| wr_data | output | DATA_W | Data of the accepted beat |
| lane_en | output | DATA_W/8 | Lane window from address and size |
| byte_mask | output | DATA_W/8 | Lanes to write |
| size_err | output | 1 | Size code too wide for the bus |
| strb_err | output | 1 | Strobe set outside the window |

## Verification
The bench walks every narrow offset for byte and halfword sizes. A design that did not clear the low address bits would move a halfword window onto lanes 1–2 or 3–4. It drives word beats at unaligned offsets, where a design that used the offset would shrink the window, and it drives every gapped strobe pattern, where a design that required contiguous strobes would raise a false error. It also sends illegal size codes and strobes outside the window, where a faulty design would write lanes or stay silent. Finally, it changes the address bus after capture and offers data before any address, which expose a design that reads its inputs live or accepts data early.

// File: rtl/lwc_pkg.sv
package lwc_pkg;

    // Control states of the address/data pairing machine.
    typedef enum logic [0:0] {
        ST_WAIT_ADDR = 1'b0,
        ST_WAIT_DATA = 1'b1
    } lwc_state_e;

endpackage

// File: rtl/lwc_ctrl.sv
module lwc_ctrl
    import lwc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic aw_valid,
    input  logic w_valid,
    output logic aw_ready,
    output logic w_ready,
    output logic aw_take,
    output logic w_take
);

    lwc_state_e state_q;
    lwc_state_e state_d;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_WAIT_ADDR;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: ADDR_TAKEN and DATA_TAKEN.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WAIT_ADDR: begin
                if (aw_valid) begin
                    state_d = ST_WAIT_DATA;
                end
            end
            ST_WAIT_DATA: begin
                if (w_valid) begin
                    state_d = ST_WAIT_ADDR;
                end
            end
            default: state_d = ST_WAIT_ADDR;
        endcase
    end

    // Outputs per state.
    always_comb begin
        aw_ready = 1'b0;
        w_ready  = 1'b0;
        unique case (state_q)
            ST_WAIT_ADDR: aw_ready = 1'b1;
            ST_WAIT_DATA: w_ready  = 1'b1;
            default: begin
                aw_ready = 1'b0;
                w_ready  = 1'b0;
            end
        endcase
    end

    assign aw_take = aw_valid && aw_ready;
    assign w_take  = w_valid && w_ready;

endmodule

// File: rtl/lwc_lane_window.sv
module lwc_lane_window #(
    parameter int LANES  = 4,
    parameter int OFS_W  = 2,
    parameter int SIZE_W = 3
) (
    input  logic [OFS_W-1:0]  ofs,
    input  logic [SIZE_W-1:0] size,
    output logic [LANES-1:0]  win,
    output logic              size_bad
);

    // Widest legal size exponent equals log2 of the lane count.
    localparam logic [SIZE_W-1:0] MAX_SIZE = SIZE_W'(OFS_W);

    logic             size_ok;
    logic [OFS_W-1:0] ofs_blk;

    assign size_bad = (size > MAX_SIZE);
    assign size_ok  = !size_bad;
    // Block index of the addressed byte at this size.
    assign ofs_blk  = ofs >> size;

    // A lane is in the window when it falls in the same size-aligned block.
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        localparam logic [OFS_W-1:0] LANE_IDX = OFS_W'(i);
        logic [OFS_W-1:0] lane_blk;
        assign lane_blk = LANE_IDX >> size;
        assign win[i]   = size_ok && (lane_blk == ofs_blk);
    end

endmodule

// File: rtl/lwc_strobe_merge.sv
module lwc_strobe_merge #(
    parameter int LANES = 4
) (
    input  logic [LANES-1:0] win,
    input  logic [LANES-1:0] strb,
    input  logic             size_bad,
    output logic [LANES-1:0] mask,
    output logic             strb_bad
);

    logic [LANES-1:0] stray;

    for (genvar i = 0; i < LANES; i++) begin : g_merge
        assign mask[i]  = strb[i] && win[i];
        assign stray[i] = strb[i] && !win[i];
    end

    // Strobe errors are only meaningful when the size itself is legal.
    assign strb_bad = !size_bad && (|stray);

endmodule

// File: rtl/axi_narrow_lane_check.sv
module axi_narrow_lane_check #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int SIZE_W = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     aw_addr,
    input  logic [SIZE_W-1:0]     aw_size,
    input  logic                  aw_valid,
    output logic                  aw_ready,
    input  logic [DATA_W-1:0]     w_data,
    input  logic [DATA_W/8-1:0]   w_strb,
    input  logic                  w_valid,
    output logic                  w_ready,
    output logic                  wr_valid,
    output logic [ADDR_W-1:0]     wr_addr,
    output logic [DATA_W-1:0]     wr_data,
    output logic [DATA_W/8-1:0]   lane_en,
    output logic [DATA_W/8-1:0]   byte_mask,
    output logic                  size_err,
    output logic                  strb_err
);

    localparam int LANES = DATA_W / 8;
    localparam int OFS_W = $clog2(LANES);

    logic              aw_take;
    logic              w_take;
    logic [ADDR_W-1:0] held_addr;
    logic [SIZE_W-1:0] held_size;
    logic [LANES-1:0]  win;
    logic [LANES-1:0]  merged;
    logic              size_bad;
    logic              strb_bad;

    lwc_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .aw_valid (aw_valid),
        .w_valid  (w_valid),
        .aw_ready (aw_ready),
        .w_ready  (w_ready),
        .aw_take  (aw_take),
        .w_take   (w_take)
    );

    // Address-channel capture, held until the data beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_addr <= '0;
            held_size <= '0;
        end else if (aw_take) begin
            held_addr <= aw_addr;
            held_size <= aw_size;
        end
    end

    lwc_lane_window #(
        .LANES  (LANES),
        .OFS_W  (OFS_W),
        .SIZE_W (SIZE_W)
    ) u_window (
        .ofs      (held_addr[OFS_W-1:0]),
        .size     (held_size),
        .win      (win),
        .size_bad (size_bad)
    );

    lwc_strobe_merge #(
        .LANES (LANES)
    ) u_merge (
        .win      (win),
        .strb     (w_strb),
        .size_bad (size_bad),
        .mask     (merged),
        .strb_bad (strb_bad)
    );

    // Result registers: loaded on the data handshake, cleared otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_valid  <= 1'b0;
            wr_addr   <= '0;
            wr_data   <= '0;
            lane_en   <= '0;
            byte_mask <= '0;
            size_err  <= 1'b0;
            strb_err  <= 1'b0;
        end else if (w_take) begin
            wr_valid  <= 1'b1;
            wr_addr   <= held_addr;
            wr_data   <= w_data;
            lane_en   <= win;
            byte_mask <= merged;
            size_err  <= size_bad;
            strb_err  <= strb_bad;
        end else begin
            wr_valid  <= 1'b0;
            lane_en   <= '0;
            byte_mask <= '0;
            size_err  <= 1'b0;
            strb_err  <= 1'b0;
        end
    end

endmodule

// File: rtl/lwc_checker.sv
module lwc_checker #(
    parameter int LANES = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             aw_valid,
    input logic             aw_ready,
    input logic             w_valid,
    input logic             w_ready,
    input logic             wr_valid,
    input logic [LANES-1:0] lane_en,
    input logic [LANES-1:0] byte_mask,
    input logic             size_err,
    input logic             strb_err
);

    p_ready_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(aw_ready && w_ready));

    p_w_after_aw_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(w_ready) |-> $past(aw_valid && aw_ready));

    p_fire_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (w_valid && w_ready) |=> wr_valid);

    p_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |=> !wr_valid);

    p_mask_in_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_mask & ~lane_en) == '0);

    p_size_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        size_err |-> (lane_en == '0 && byte_mask == '0 && !strb_err));

    p_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_valid |-> (lane_en == '0 && byte_mask == '0 && !size_err && !strb_err));

    p_lane_pow2_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !size_err) |->
            (lane_en != '0 && ($countones(lane_en) & ($countones(lane_en) - 1)) == 0));

endmodule

bind axi_narrow_lane_check lwc_checker #(.LANES(LANES)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .aw_valid  (aw_valid),
    .aw_ready  (aw_ready),
    .w_valid   (w_valid),
    .w_ready   (w_ready),
    .wr_valid  (wr_valid),
    .lane_en   (lane_en),
    .byte_mask (byte_mask),
    .size_err  (size_err),
    .strb_err  (strb_err)
);

// File: tb/test_axi_narrow_lane_check.sv
module test_axi_narrow_lane_check;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] aw_addr = '0;
    logic [2:0]  aw_size = '0;
    logic        aw_valid = 1'b0;
    logic        aw_ready;
    logic [31:0] w_data = '0;
    logic [3:0]  w_strb = '0;
    logic        w_valid = 1'b0;
    logic        w_ready;
    logic        wr_valid;
    logic [15:0] wr_addr;
    logic [31:0] wr_data;
    logic [3:0]  lane_en;
    logic [3:0]  byte_mask;
    logic        size_err;
    logic        strb_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [15:0] addr;
        logic [31:0] data;
        logic [3:0]  en;
        logic [3:0]  mask;
        logic        serr;
        logic        berr;
        string       tag;
    } exp_t;

    exp_t sb[$];

    always #4 clk = ~clk;

    axi_narrow_lane_check i_axi_narrow_lane_check (
        .clk(clk), .rst_n(rst_n),
        .aw_addr(aw_addr), .aw_size(aw_size), .aw_valid(aw_valid), .aw_ready(aw_ready),
        .w_data(w_data), .w_strb(w_strb), .w_valid(w_valid), .w_ready(w_ready),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
        .lane_en(lane_en), .byte_mask(byte_mask),
        .size_err(size_err), .strb_err(strb_err)
    );

    task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Driver: compute expected result from the requirements, queue it, drive the beat.
    task automatic write_beat(input logic [15:0] addr, input logic [2:0] size,
                              input logic [3:0] strb, input logic [31:0] data,
                              input string tag, input bit together);
        exp_t e;
        int n;
        logic [3:0] base;
        e.addr = addr; e.data = data; e.tag = tag;
        if (size > 3'd2) begin
            e.en = 4'b0; e.serr = 1'b1; e.berr = 1'b0;
        end else begin
            n = 1 << size;
            base = {2'b00, addr[1:0]} & ~4'(n - 1);
            e.en = 4'(((1 << n) - 1) << base);
            e.serr = 1'b0;
            e.berr = |(strb & ~e.en);
        end
        e.mask = strb & e.en;
        sb.push_back(e);
        @(negedge clk);
        aw_addr = addr; aw_size = size; aw_valid = 1'b1;
        if (together) begin
            w_valid = 1'b1; w_data = data; w_strb = strb;
        end
        while (!aw_ready) @(negedge clk);
        @(negedge clk);
        aw_valid = 1'b0; aw_addr = ~addr; aw_size = 3'd7;   // scramble after capture (R8)
        w_valid = 1'b1; w_data = data; w_strb = strb;
        while (!w_ready) @(negedge clk);
        @(negedge clk);
        w_valid = 1'b0; w_strb = 4'hF; w_data = ~data;
        @(negedge clk);
        check("R9", "wr_valid one cycle only", {31'b0, wr_valid}, 32'd0);
    endtask

    // Monitor: pop and compare whenever a result is presented.
    always @(negedge clk) begin
        if (rst_n && wr_valid) begin
            if (sb.size() == 0) begin
                check("R9", "unexpected result", 32'd1, 32'd0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(e.tag, "lane_en", {28'b0, lane_en}, {28'b0, e.en});
                check(e.tag, "byte_mask", {28'b0, byte_mask}, {28'b0, e.mask});
                check(e.tag, "size_err", {31'b0, size_err}, {31'b0, e.serr});
                check(e.tag, "strb_err", {31'b0, strb_err}, {31'b0, e.berr});
                check("R8", "wr_addr", {16'b0, wr_addr}, {16'b0, e.addr});
                check("R9", "wr_data", wr_data, e.data);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R6", "aw_ready in reset", {31'b0, aw_ready}, 32'd1);
        check("R6", "w_ready in reset", {31'b0, w_ready}, 32'd0);
        check("R6", "wr_valid in reset", {31'b0, wr_valid}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R6", "byte_mask after reset", {28'b0, byte_mask}, 32'd0);
        check("R6", "aw_ready after reset", {31'b0, aw_ready}, 32'd1);

        // R7: data offered before any address is not accepted.
        w_valid = 1'b1; w_strb = 4'hF; w_data = 32'hDEAD_BEEF;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check("R7", "w_ready before address", {31'b0, w_ready}, 32'd0);
            check("R7", "no result before address", {31'b0, wr_valid}, 32'd0);
        end
        w_valid = 1'b0;

        // R1: byte and halfword windows at every offset.
        for (int o = 0; o < 4; o++) begin
            write_beat(16'h00C0 + 16'(o), 3'd0, 4'(1 << o), 32'h1100_0000 + 32'(o), "R1", 1'b0);
            write_beat(16'h0140 + 16'(o), 3'd1, 4'hF & (4'b0011 << (o & 2)), 32'h2200_0000 + 32'(o), "R1", 1'b0);
        end
        // R10: word size ignores the low address bits.
        for (int o = 0; o < 4; o++) begin
            write_beat(16'h0200 + 16'(o), 3'd2, 4'hF, 32'h3300_0000 + 32'(o), "R10", 1'b0);
        end
        // R3: strobe clears lanes inside the window.
        write_beat(16'h00C0, 3'd2, 4'b0100, 32'hA5A5_5A5A, "R3", 1'b0);
        write_beat(16'h00C2, 3'd1, 4'b1000, 32'h0BAD_F00D, "R3", 1'b1);
        // R5: gapped patterns on aligned word beats.
        write_beat(16'h0300, 3'd2, 4'b0101, 32'h5000_0001, "R5", 1'b0);
        write_beat(16'h0304, 3'd2, 4'b1001, 32'h5000_0002, "R5", 1'b1);
        write_beat(16'h0308, 3'd2, 4'b1010, 32'h5000_0003, "R5", 1'b0);
        write_beat(16'h030C, 3'd2, 4'b1011, 32'h5000_0004, "R5", 1'b0);
        write_beat(16'h0310, 3'd2, 4'b1101, 32'h5000_0005, "R5", 1'b1);
        // R4: strobes outside the window.
        write_beat(16'h00C2, 3'd0, 4'b1111, 32'h4000_0001, "R4", 1'b0);
        write_beat(16'h0400, 3'd1, 4'b0110, 32'h4000_0002, "R4", 1'b0);
        write_beat(16'h0403, 3'd1, 4'b0111, 32'h4000_0003, "R4", 1'b0);
        // R2: illegal size codes.
        write_beat(16'h0500, 3'd3, 4'b1111, 32'h2000_0003, "R2", 1'b0);
        write_beat(16'h0501, 3'd7, 4'b0010, 32'h2000_0007, "R2", 1'b1);
        // Legal beat after an illegal one recovers.
        write_beat(16'h0601, 3'd0, 4'b0010, 32'h6000_0001, "R8", 1'b0);

        repeat (3) @(negedge clk);
        check("R9", "scoreboard drained", 32'(sb.size()), 32'd0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule